// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside the control unit of a small 8-bit core and owns everything that happens between "an interrupt is due" and "the first opcode of the handler is fetched". It latches hardware and software-trap requests and decides at each instruction boundary whether one may be taken. Once it takes a request, it writes the core's context to a downward-growing memory stack one byte per cycle and raises the mask bit in the condition code. It then reads the 16-bit handler address and hands it to the program counter. A return command from the decoder runs the mirror sequence, reading the context back and handing each register to the core through its own load strobe.

The block keeps the stack pointer itself. It holds a stall signal high for the whole of either sequence. Hardware requests that arrive while the mask bit is set are kept until the mask is cleared. A trap is accepted whatever the mask says. The Y index register is outside the saved context, so a handler that uses it must save it itself.

Top module: `irq_ctx_seq`

## Requirements
- R1: After reset, busy, mem_we, mem_re, pc_ld, x_ld, a_ld and cc_ld are low and sp_o equals SP_RESET (0x01FF by default).
- R2: A hw_irq pulse is latched. At the next insn_done that finds cc_i bit 3 (the mask bit) clear, the entry sequence starts, with busy and the first stack write in the cycle after insn_done.
- R3: While cc_i bit 3 is set, a latched hardware request starts no sequence. It stays pending and is taken at the first insn_done that finds the bit clear.
- R4: A latched trap_req is taken at insn_done even with cc_i bit 3 set. If both kinds are pending, the trap goes first and the hardware request stays pending for a later boundary.
- R5: Entry writes five bytes in consecutive cycles: PC[7:0], PC[15:8], X, A, CC. The first goes to address sp_o and each write lowers sp_o by one. No sixth byte (no Y) is written.
- R6: In the cycle after the last push, cc_ld pulses with cc_o equal to the captured condition code with bit 3 set.
- R7: The handler address is read high byte first from the vector base, then low byte from base+1. The trap base is 0xFFFC and the hardware base is 0xFFFE. In the second read cycle pc_ld pulses with pc_o = {high, low}.
- R8: busy stays high for exactly seven cycles of entry (five pushes and two vector reads) and is low in the cycle after pc_ld. sp_o ends five below its start value.
- R9: An iret_req while idle reads five bytes from sp_o+1 upward, raising sp_o by one per read. The loads come in this order: cc_ld with the first byte, a_ld with the second, x_ld with the third, then pc_ld with pc_o = {fourth, fifth}. This restores the pre-entry context, mask bit included.
- R10: A pending request is cleared when its entry starts, so one request pulse produces exactly one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done | input | 1 | Instruction boundary strobe from the core |
| hw_irq | input | 1 | Hardware interrupt request |
| trap_req | input | 1 | Software trap request from the decoder |
| iret_req | input | 1 | Return-from-interrupt command from the decoder |
| pc_i | input | 16 | Current program counter |
| x_i | input | 8 | Current X index register |
| a_i | input | 8 | Current accumulator |
| cc_i | input | 8 | Current condition code; bit 3 is the mask |
| mem_rdata | input | 8 | Read data, valid in the same cycle as mem_re |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Stack or vector read strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Byte being pushed |
| busy | output | 1 | Stall request to the core during a sequence |
| sp_o | output | 16 | Stack pointer |
| pc_ld | output | 1 | Load strobe for the program counter |
| pc_o | output | 16 | Value for the program counter |
| x_ld | output | 1 | Load strobe for X |
| x_o | output | 8 | Value for X |
| a_ld | output | 1 | Load strobe for the accumulator |
| a_o | output | 8 | Value for the accumulator |
| cc_ld | output | 1 | Load strobe for the condition code |
| cc_o | output | 8 | Value for the condition code |

## Verification
The bench raises a hardware request under a set mask, keeps it waiting across several boundaries and then clears the mask. A design that drops masked requests never enters, and one that ignores the mask enters too early. Trap and hardware requests are raised together. A wrong priority shows up as the wrong vector address, and a pending flag cleared on the wrong source loses the second entry. Each push and pop is compared byte by byte against address and order, which catches a swapped PC half, an off-by-one stack pointer or a pop that restores the mask bit from the wrong byte. A second boundary after a completed entry and return catches a pending flag that is never cleared.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_PUSH = 2'd1,
    SQ_VEC  = 2'd2,
    SQ_POP  = 2'd3
  } sq_state_t;
endpackage

// File: rtl/irq_req_latch.sv
// Sticky request flags: set by a request, cleared when the matching entry begins.
module irq_req_latch #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= (flag_q & ~clr[g]) | req[g];
    end
    assign pend[g] = flag_q;
  end
endmodule

// File: rtl/irq_take_arb.sv
// Decides, while idle, whether to start a return, a trap entry or a hardware entry.
module irq_take_arb (
  input  logic idle,
  input  logic insn_done,
  input  logic iret_req,
  input  logic trap_pend,
  input  logic hw_pend,
  input  logic mask,
  output logic go_ret,
  output logic go_trap,
  output logic go_hw
);
  logic boundary;
  assign boundary = idle & insn_done & ~iret_req;
  assign go_ret   = idle & iret_req;
  assign go_trap  = boundary & trap_pend;
  assign go_hw    = boundary & hw_pend & ~trap_pend & ~mask;
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
#(
  parameter int          DW       = 8,
  parameter int          AW       = 16,
  parameter int          I_BIT    = 3,
  parameter logic [15:0] SP_RESET = 16'h01FF,
  parameter logic [15:0] TRAP_VEC = 16'hFFFC,
  parameter logic [15:0] HW_VEC   = 16'hFFFE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_trap,
  input  logic          go_hw,
  input  logic          go_ret,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] cc_i,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] sp_o,
  output logic          idle,
  output logic          pc_ld,
  output logic [AW-1:0] pc_o,
  output logic          x_ld,
  output logic [DW-1:0] x_o,
  output logic          a_ld,
  output logic [DW-1:0] a_o,
  output logic          cc_ld,
  output logic [DW-1:0] cc_o
);
  localparam int PCB = AW / DW;      // bytes in the program counter
  localparam int CTX = PCB + 3;      // PC bytes, X, A, CC
  localparam int CW  = $clog2(CTX);
  localparam logic [DW-1:0] IMASK = DW'(1) << I_BIT;

  // Push slot k: PC bytes low first, then X, A, CC.
  function automatic logic [DW-1:0] ctx_byte(int k, logic [AW-1:0] pc,
                                             logic [DW-1:0] x, logic [DW-1:0] a,
                                             logic [DW-1:0] cc);
    if (k < PCB)          return pc[k*DW +: DW];
    else if (k == PCB)    return x;
    else if (k == PCB+1)  return a;
    else                  return cc;
  endfunction

  function automatic logic [AW-1:0] put_byte(logic [AW-1:0] w, int pos, logic [DW-1:0] b);
    logic [AW-1:0] r;
    r = w;
    if (pos >= 0 && pos < PCB) r[pos*DW +: DW] = b;
    return r;
  endfunction

  sq_state_t     st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] sp, acc, snap_pc;
  logic [DW-1:0] snap_x, snap_a, snap_cc;
  logic          is_trap;
  logic [AW-1:0] vbase, merged;
  int            ci, pos;

  assign ci     = int'(cnt);
  assign vbase  = is_trap ? TRAP_VEC[AW-1:0] : HW_VEC[AW-1:0];
  assign pos    = (st == SQ_VEC) ? (PCB - 1 - ci) : (CTX - 1 - ci);
  assign merged = put_byte(acc, pos, mem_rdata);
  assign sp_o   = sp;
  assign idle   = (st == SQ_IDLE);

  always_comb begin
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_addr  = sp;
    mem_wdata = ctx_byte(ci, snap_pc, snap_x, snap_a, snap_cc);
    pc_ld     = 1'b0;
    x_ld      = 1'b0;
    a_ld      = 1'b0;
    cc_ld     = 1'b0;
    pc_o      = merged;
    x_o       = mem_rdata;
    a_o       = mem_rdata;
    cc_o      = mem_rdata;
    case (st)
      SQ_PUSH: mem_we = 1'b1;
      SQ_VEC: begin
        mem_re   = 1'b1;
        mem_addr = vbase + AW'(cnt);
        cc_ld    = (ci == 0);
        cc_o     = snap_cc | IMASK;
        pc_ld    = (ci == PCB - 1);
      end
      SQ_POP: begin
        mem_re   = 1'b1;
        mem_addr = sp + AW'(1);
        cc_ld    = (pos == CTX - 1);
        a_ld     = (pos == PCB + 1);
        x_ld     = (pos == PCB);
        pc_ld    = (pos == 0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      cnt     <= '0;
      sp      <= SP_RESET[AW-1:0];
      acc     <= '0;
      snap_pc <= '0;
      snap_x  <= '0;
      snap_a  <= '0;
      snap_cc <= '0;
      is_trap <= 1'b0;
    end else begin
      case (st)
        SQ_IDLE: begin
          cnt <= '0;
          if (go_ret) begin
            st <= SQ_POP;
          end else if (go_trap || go_hw) begin
            st      <= SQ_PUSH;
            is_trap <= go_trap;
            snap_pc <= pc_i;
            snap_x  <= x_i;
            snap_a  <= a_i;
            snap_cc <= cc_i;
          end
        end
        SQ_PUSH: begin
          sp <= sp - AW'(1);
          if (ci == CTX - 1) begin
            st  <= SQ_VEC;
            cnt <= '0;
          end else cnt <= cnt + CW'(1);
        end
        SQ_VEC: begin
          acc <= merged;
          if (ci == PCB - 1) st <= SQ_IDLE;
          else cnt <= cnt + CW'(1);
        end
        SQ_POP: begin
          sp  <= sp + AW'(1);
          acc <= merged;
          if (ci == CTX - 1) st <= SQ_IDLE;
          else cnt <= cnt + CW'(1);
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq #(
  parameter int          DW       = 8,
  parameter int          AW       = 16,
  parameter int          I_BIT    = 3,
  parameter logic [15:0] SP_RESET = 16'h01FF,
  parameter logic [15:0] TRAP_VEC = 16'hFFFC,
  parameter logic [15:0] HW_VEC   = 16'hFFFE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          insn_done,
  input  logic          hw_irq,
  input  logic          trap_req,
  input  logic          iret_req,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] cc_i,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          busy,
  output logic [AW-1:0] sp_o,
  output logic          pc_ld,
  output logic [AW-1:0] pc_o,
  output logic          x_ld,
  output logic [DW-1:0] x_o,
  output logic          a_ld,
  output logic [DW-1:0] a_o,
  output logic          cc_ld,
  output logic [DW-1:0] cc_o
);
  // Named internal events, also observed by the checker.
  logic       idle, go_ret, go_trap, go_hw;
  logic [1:0] pend;
  logic       trap_pend, hw_pend;

  assign trap_pend = pend[1];
  assign hw_pend   = pend[0];
  assign busy      = ~idle;

  irq_req_latch #(.N(2)) u_latch (
    .clk  (clk),
    .rst_n(rst_n),
    .req  ({trap_req, hw_irq}),
    .clr  ({go_trap, go_hw}),
    .pend (pend)
  );

  irq_take_arb u_arb (
    .idle     (idle),
    .insn_done(insn_done),
    .iret_req (iret_req),
    .trap_pend(trap_pend),
    .hw_pend  (hw_pend),
    .mask     (cc_i[I_BIT]),
    .go_ret   (go_ret),
    .go_trap  (go_trap),
    .go_hw    (go_hw)
  );

  irq_seq_fsm #(
    .DW(DW), .AW(AW), .I_BIT(I_BIT),
    .SP_RESET(SP_RESET), .TRAP_VEC(TRAP_VEC), .HW_VEC(HW_VEC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_trap  (go_trap),
    .go_hw    (go_hw),
    .go_ret   (go_ret),
    .pc_i     (pc_i),
    .x_i      (x_i),
    .a_i      (a_i),
    .cc_i     (cc_i),
    .mem_rdata(mem_rdata),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .sp_o     (sp_o),
    .idle     (idle),
    .pc_ld    (pc_ld),
    .pc_o     (pc_o),
    .x_ld     (x_ld),
    .x_o      (x_o),
    .a_ld     (a_ld),
    .a_o      (a_o),
    .cc_ld    (cc_ld),
    .cc_o     (cc_o)
  );
endmodule

// File: rtl/irq_ctx_seq_chk.sv
module irq_ctx_seq_chk #(
  parameter int DW    = 8,
  parameter int AW    = 16,
  parameter int I_BIT = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_we,
  input logic          mem_re,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] sp_o,
  input logic          busy,
  input logic [DW-1:0] cc_i,
  input logic [DW-1:0] cc_o,
  input logic          cc_ld,
  input logic          pc_ld,
  input logic          go_hw,
  input logic          go_trap,
  input logic          go_ret
);
  // R5
  push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr == sp_o);
  // R5
  push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp_o == $past(sp_o) - AW'(1));
  // R5
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  // R2
  hw_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_hw |-> !cc_i[I_BIT]);
  // R8
  entry_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_hw || go_trap) |=> busy && mem_we);
  // R8
  load_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_ld |=> !busy);
  // R6
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_ld && $past(mem_we)) |-> cc_o[I_BIT]);
  // R9
  pop_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_ret |=> mem_re && mem_addr == sp_o + AW'(1));
endmodule

bind irq_ctx_seq irq_ctx_seq_chk #(.DW(DW), .AW(AW), .I_BIT(I_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_re(mem_re),
  .mem_addr(mem_addr), .sp_o(sp_o), .busy(busy), .cc_i(cc_i), .cc_o(cc_o),
  .cc_ld(cc_ld), .pc_ld(pc_ld), .go_hw(go_hw), .go_trap(go_trap), .go_ret(go_ret)
);

// File: tb/tb_irq_ctx_seq.sv
module tb_irq_ctx_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_done = 1'b0, hw_irq = 1'b0, trap_req = 1'b0, iret_req = 1'b0;
  logic [15:0] pc_i = '0;
  logic [7:0]  x_i = '0, a_i = '0, cc_i = '0;
  logic [7:0]  mem_rdata;
  logic        mem_we, mem_re, busy, pc_ld, x_ld, a_ld, cc_ld;
  logic [15:0] mem_addr, sp_o, pc_o;
  logic [7:0]  mem_wdata, x_o, a_o, cc_o;

  int nchk = 0, nerr = 0;
  logic [15:0] esp = 16'h01FF;   // bench model of the stack pointer
  logic [7:0]  bmem [0:1023];

  always #2 clk = ~clk;          // 250 MHz

  irq_ctx_seq dut (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .hw_irq(hw_irq),
    .trap_req(trap_req), .iret_req(iret_req), .pc_i(pc_i), .x_i(x_i),
    .a_i(a_i), .cc_i(cc_i), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy),
    .sp_o(sp_o), .pc_ld(pc_ld), .pc_o(pc_o), .x_ld(x_ld), .x_o(x_o),
    .a_ld(a_ld), .a_o(a_o), .cc_ld(cc_ld), .cc_o(cc_o)
  );

  assign mem_rdata = bmem[mem_addr[9:0]];
  always @(posedge clk) if (mem_we) bmem[mem_addr[9:0]] <= mem_wdata;

  // {trap, pc, x, a, cc}
  localparam logic [40:0] VTAB [4] = '{
    {1'b0, 16'h1234, 8'h56, 8'h78, 8'h00},
    {1'b1, 16'hABCD, 8'h11, 8'h22, 8'h08},
    {1'b0, 16'h00FF, 8'hFF, 8'h00, 8'hF7},
    {1'b1, 16'hFFFF, 8'h80, 8'h01, 8'hFF}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] vec_of(input bit trap);
    return trap ? 16'h4010 : 16'h5020;
  endfunction

  function automatic logic [7:0] slot(input int k, input logic [15:0] pc,
                                      input logic [7:0] x, input logic [7:0] a, input logic [7:0] cc);
    case (k)
      0: return pc[7:0];
      1: return pc[15:8];
      2: return x;
      3: return a;
      default: return cc;
    endcase
  endfunction

  task automatic pulse_done();
    insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0;
  endtask

  // Called at the negedge after the insn_done cycle that starts entry.
  task automatic observe_entry(input bit trap, input logic [15:0] pc, input logic [7:0] x,
                               input logic [7:0] a, input logic [7:0] cc, input string tag);
    logic [15:0] base, sp0;
    base = trap ? 16'hFFFC : 16'hFFFE;
    sp0  = esp;
    for (int i = 0; i < 7; i++) begin
      if (i < 5)
        chk(busy && mem_we && !mem_re && mem_addr == sp0 - 16'(i) &&
            mem_wdata == slot(i, pc, x, a, cc), i == 0 ? tag : "R5",
            {busy, mem_we, mem_addr, mem_wdata}, {2'b11, sp0 - 16'(i), slot(i, pc, x, a, cc)});
      else if (i == 5)
        chk(busy && mem_re && mem_addr == base && cc_ld && cc_o == (cc | 8'h08) && !pc_ld,
            "R6", {mem_addr, cc_ld, cc_o}, {base, 1'b1, cc | 8'h08});
      else
        chk(busy && mem_re && mem_addr == base + 16'd1 && pc_ld && pc_o == vec_of(trap),
            "R7", {mem_addr, pc_o}, {base + 16'd1, vec_of(trap)});
      @(negedge clk);
    end
    esp = sp0 - 16'd5;
    chk(!busy && !mem_we && sp_o == esp, "R8", {busy, sp_o}, {1'b0, esp});
  endtask

  task automatic do_return(input logic [15:0] pc, input logic [7:0] x,
                           input logic [7:0] a, input logic [7:0] cc);
    logic [15:0] sp0;
    sp0 = esp;
    iret_req = 1'b1;
    @(negedge clk);
    iret_req = 1'b0;
    for (int i = 0; i < 5; i++) begin
      case (i)
        0: chk(mem_re && mem_addr == sp0 + 16'd1 && cc_ld && cc_o == cc, "R9",
               {mem_addr, cc_o}, {sp0 + 16'd1, cc});
        1: chk(mem_re && mem_addr == sp0 + 16'd2 && a_ld && a_o == a, "R9",
               {mem_addr, a_o}, {sp0 + 16'd2, a});
        2: chk(mem_re && mem_addr == sp0 + 16'd3 && x_ld && x_o == x, "R9",
               {mem_addr, x_o}, {sp0 + 16'd3, x});
        3: chk(mem_re && mem_addr == sp0 + 16'd4 && !pc_ld && !cc_ld, "R9",
               {mem_addr, pc_ld}, {sp0 + 16'd4, 1'b0});
        default: chk(mem_re && mem_addr == sp0 + 16'd5 && pc_ld && pc_o == pc, "R9",
               {mem_addr, pc_o}, {sp0 + 16'd5, pc});
      endcase
      @(negedge clk);
    end
    esp = sp0 + 16'd5;
    chk(!busy && sp_o == esp, "R9", {busy, sp_o}, {1'b0, esp});
  endtask

  task automatic quiet(input int n, input string req);
    bit ok;
    ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      if (busy || mem_we || mem_re) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok, req, {busy, mem_we, mem_re}, 3'b000);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) bmem[i] = 8'h00;
    bmem[10'h3FC] = 8'h40; bmem[10'h3FD] = 8'h10;   // trap vector
    bmem[10'h3FE] = 8'h50; bmem[10'h3FF] = 8'h20;   // hardware vector
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !mem_we && !mem_re && !pc_ld && !x_ld && !a_ld && !cc_ld && sp_o == 16'h01FF,
        "R1", {busy, mem_we, mem_re, pc_ld, sp_o}, {4'b0000, 16'h01FF});

    // Table walk: entry then return for each context.
    for (int v = 0; v < 4; v++) begin
      {trap_req, pc_i, x_i, a_i, cc_i} = VTAB[v];
      hw_irq = ~VTAB[v][40];
      @(negedge clk);
      trap_req = 1'b0; hw_irq = 1'b0;
      pulse_done();
      observe_entry(VTAB[v][40], VTAB[v][39:24], VTAB[v][23:16], VTAB[v][15:8], VTAB[v][7:0],
                    VTAB[v][40] ? "R4" : "R2");
      do_return(VTAB[v][39:24], VTAB[v][23:16], VTAB[v][15:8], VTAB[v][7:0]);
    end

    // R3: masked hardware request is held across boundaries.
    pc_i = 16'h2468; x_i = 8'h13; a_i = 8'h57; cc_i = 8'h08;
    hw_irq = 1'b1; @(negedge clk); hw_irq = 1'b0;
    pulse_done();
    quiet(2, "R3");
    pulse_done();
    quiet(2, "R3");
    cc_i = 8'h00;
    pulse_done();
    observe_entry(1'b0, 16'h2468, 8'h13, 8'h57, 8'h00, "R3");
    do_return(16'h2468, 8'h13, 8'h57, 8'h00);

    // R10: the served request does not come back.
    pulse_done();
    quiet(3, "R10");

    // R4: trap beats hardware; hardware stays pending.
    pc_i = 16'h0F0F; x_i = 8'hA5; a_i = 8'h5A; cc_i = 8'h00;
    hw_irq = 1'b1; trap_req = 1'b1; @(negedge clk);
    hw_irq = 1'b0; trap_req = 1'b0;
    pulse_done();
    observe_entry(1'b1, 16'h0F0F, 8'hA5, 8'h5A, 8'h00, "R4");
    do_return(16'h0F0F, 8'hA5, 8'h5A, 8'h00);
    pulse_done();
    observe_entry(1'b0, 16'h0F0F, 8'hA5, 8'h5A, 8'h00, "R4");
    do_return(16'h0F0F, 8'hA5, 8'h5A, 8'h00);
    pulse_done();
    quiet(2, "R10");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule